// File: doc/BRIEF.md
# Serial Bit-Rate Divider with Receive Sampler

This block turns the system clock into the timing strobes of a combined asynchronous/synchronous serial port. A reload value `n` and three mode bits are written through a small strobe interface. A base counter counts `n+1` clocks and then emits a one-clock sample strobe. A prescale counter counts these sample strobes and, after 64, 16 or 4 of them, emits a one-clock bit tick. The mode bits choose whether the reload is the low byte alone or the full high:low pair, and which prescale multiple applies.

Any configuration write restarts both counters at once, so a new rate takes effect at once and does not wait for the running period to finish. A reload of zero is not a valid setting. It is flagged, and no strobes are produced while it is in effect.

The same timing drives a receive-line sampler. Where the bit has 64 or 16 sample slots, it takes three samples around the middle of the bit and resolves the bit by majority vote. At the fast 4-slot rate it takes one sample at the middle. The resolved bit is presented with a valid pulse one cycle after each bit tick.

Top module: `ser_rate_gen`

## Requirements
- R1: After reset both reload bytes and all mode bits are 0. `bad_cfg_o` is 1. `sample_stb_o`, `bit_tick_o` and `rx_bit_vld_o` are 0.
- R2: With `wide` = 0 the reload `n` is the low byte alone. A different high byte has no effect on the bit period.
- R3: With `wide` = 1 the reload `n` is {high byte, low byte}, with the high byte in bits 15:8.
- R4: With `sync`=0, `wide`=0 and `fast`=0, `bit_tick_o` repeats every 64·(n+1) clocks. `sample_stb_o` fires exactly 64 times per bit period, once every n+1 clocks.
- R5: With `sync`=0 and exactly one of `wide`/`fast` set, the bit period is 16·(n+1) clocks, with 16 sample strobes per period.
- R6: With `sync`=0 and both `wide` and `fast` set, the bit period is 4·(n+1) clocks. With `sync`=1 the period is also 4·(n+1), and `fast` has no effect.
- R7: A write strobe (`wr_lo_i`, `wr_hi_i` or `wr_mode_i`) that is high in cycle c clears both counters. The next `bit_tick_o` appears in cycle c + P·(n+1), where P is the prescale of the new mode. `wr_mode_i` loads `wr_data_i[2]`=sync, `[1]`=wide and `[0]`=fast.
- R8: When the effective reload is 0, `bad_cfg_o` is 1 and neither strobe fires. Otherwise `bad_cfg_o` is 0.
- R9: Number the sample strobes of a bit from 0. When P is 64 or 16, the resolved bit is the majority of `rx_i` at strobes P/2-1, P/2 and P/2+1. When P is 4, it is `rx_i` at strobe 2. The resolved bit appears on `rx_bit_o`, with `rx_bit_vld_o` high, in the cycle after `bit_tick_o`.
- R10: `bit_tick_o` is high only in a cycle in which `sample_stb_o` is high.
- R11: With low byte 25 in the default mode, the bit period is 1664 clocks. At a 16 MHz clock this gives 9615 baud, which is +0.16 % against 9600.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_lo_i | input | 1 | Write low reload byte from wr_data_i |
| wr_hi_i | input | 1 | Write high reload byte from wr_data_i |
| wr_mode_i | input | 1 | Write mode bits from wr_data_i[2:0] |
| wr_data_i | input | 8 | Write data |
| rx_i | input | 1 | Receive line, already synchronous to clk_i |
| sample_stb_o | output | 1 | One-clock strobe each n+1 clocks |
| bit_tick_o | output | 1 | One-clock strobe at the end of each bit period |
| bad_cfg_o | output | 1 | Effective reload is zero |
| rx_bit_o | output | 1 | Last resolved receive bit |
| rx_bit_vld_o | output | 1 | Pulse marking a newly resolved bit |

## Verification
The bench builds the block with its default parameters: 8-bit reload bytes, a 16-bit counter and a 6-bit prescale counter. This brings every mode and the full 16-bit reload within reach, including a high byte above zero. Small reloads of 1 to 7 keep the 64-slot periods short, so the random mode and divisor draws can each check the latency from a write and a full period. The vote check uses reload 1 and a fresh random pattern on the receive line for every bit. This exposes a wrong sample slot, and a vote used where a single sample belongs.

// File: rtl/ser_rate_pkg.sv
package ser_rate_pkg;

  typedef enum logic [1:0] {
    DIV64 = 2'd0,
    DIV16 = 2'd1,
    DIV4  = 2'd2
  } div_e;

  typedef struct packed {
    logic sync;
    logic wide;
    logic fast;
  } mode_t;

  function automatic div_e pick_div(mode_t m);
    if (m.sync || (m.wide && m.fast)) return DIV4;
    if (m.wide || m.fast)             return DIV16;
    return DIV64;
  endfunction

  // three-sample vote everywhere except the 4-slot rates
  function automatic logic use_vote(mode_t m);
    return !(m.sync || (m.wide && m.fast));
  endfunction

endpackage

// File: rtl/rate_cfg_regs.sv
module rate_cfg_regs
  import ser_rate_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic              wr_mode_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic [BYTE_W-1:0] lo_o,
  output logic [BYTE_W-1:0] hi_o,
  output mode_t             mode_o,
  output logic              restart_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_o   <= '0;
      hi_o   <= '0;
      mode_o <= '0;
    end else begin
      if (wr_lo_i)   lo_o   <= wr_data_i;
      if (wr_hi_i)   hi_o   <= wr_data_i;
      if (wr_mode_i) mode_o <= mode_t'(wr_data_i[2:0]);
    end
  end

  assign restart_o = wr_lo_i | wr_hi_i | wr_mode_i;

  AST_LO_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo_i |=> lo_o == $past(wr_data_i)); // R7

  AST_HI_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hi_i |=> hi_o == $past(wr_data_i)); // R3

endmodule

// File: rtl/rate_divider.sv
module rate_divider #(
  parameter int CNT_W = 16,
  parameter int PS_W  = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic [PS_W-1:0]  pmax_i,
  output logic             zero_o,
  output logic             stb_o,
  output logic             tick_o,
  output logic [PS_W-1:0]  ps_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [PS_W-1:0]  ps_q;
  logic             hit;

  assign zero_o = (reload_i == '0);
  assign hit    = !zero_o && (cnt_q == reload_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ps_q  <= '0;
    end else if (restart_i || zero_o) begin
      cnt_q <= '0;
      ps_q  <= '0;
    end else if (hit) begin
      cnt_q <= '0;
      ps_q  <= (ps_q == pmax_i) ? '0 : ps_q + 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign stb_o  = hit;
  assign tick_o = hit && (ps_q == pmax_i);
  assign ps_o   = ps_q;

  AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= reload_i); // R4

  AST_PS_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ps_q <= pmax_i); // R5

  AST_RESTART_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (cnt_q == '0) && (ps_q == '0)); // R7

  AST_TICK_ON_STB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> stb_o); // R10

endmodule

// File: rtl/rx_vote_sampler.sv
module rx_vote_sampler #(
  parameter int PS_W = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            stb_i,
  input  logic            tick_i,
  input  logic [PS_W-1:0] ps_i,
  input  logic [PS_W-1:0] mid_i,
  input  logic            vote_i,
  input  logic            rx_i,
  output logic            bit_o,
  output logic            vld_o
);

  logic s_early, s_mid, s_late;
  logic maj;

  assign maj = (s_early & s_mid) | (s_early & s_late) | (s_mid & s_late);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_early <= 1'b0;
      s_mid   <= 1'b0;
      s_late  <= 1'b0;
      bit_o   <= 1'b0;
      vld_o   <= 1'b0;
    end else begin
      if (stb_i && ps_i == mid_i - 1'b1) s_early <= rx_i;
      if (stb_i && ps_i == mid_i)        s_mid   <= rx_i;
      if (stb_i && ps_i == mid_i + 1'b1) s_late  <= rx_i;
      if (tick_i) bit_o <= vote_i ? maj : s_mid;
      vld_o <= tick_i;
    end
  end

  AST_VLD_AFTER_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> vld_o); // R9

  AST_VLD_NEEDS_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> $past(tick_i)); // R9

  AST_BIT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(tick_i) |-> $stable(bit_o)); // R9

endmodule

// File: rtl/ser_rate_gen.sv
module ser_rate_gen
  import ser_rate_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int PS_W   = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic              wr_mode_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              rx_i,
  output logic              sample_stb_o,
  output logic              bit_tick_o,
  output logic              bad_cfg_o,
  output logic              rx_bit_o,
  output logic              rx_bit_vld_o
);

  localparam int CNT_W = 2 * BYTE_W;

  logic [BYTE_W-1:0] lo, hi;
  mode_t             mode;
  logic              restart;
  logic [CNT_W-1:0]  reload;
  logic [PS_W-1:0]   pmax, mid, ps;
  logic              vote;

  rate_cfg_regs #(.BYTE_W(BYTE_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_lo_i   (wr_lo_i),
    .wr_hi_i   (wr_hi_i),
    .wr_mode_i (wr_mode_i),
    .wr_data_i (wr_data_i),
    .lo_o      (lo),
    .hi_o      (hi),
    .mode_o    (mode),
    .restart_o (restart)
  );

  // high byte only counts in wide mode
  assign reload = mode.wide ? {hi, lo} : {{BYTE_W{1'b0}}, lo};

  always_comb begin
    unique case (pick_div(mode))
      DIV64:   pmax = PS_W'(63);
      DIV16:   pmax = PS_W'(15);
      default: pmax = PS_W'(3);
    endcase
  end

  assign mid  = PS_W'((int'(pmax) + 1) / 2);
  assign vote = use_vote(mode);

  rate_divider #(.CNT_W(CNT_W), .PS_W(PS_W)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .reload_i  (reload),
    .pmax_i    (pmax),
    .zero_o    (bad_cfg_o),
    .stb_o     (sample_stb_o),
    .tick_o    (bit_tick_o),
    .ps_o      (ps)
  );

  rx_vote_sampler #(.PS_W(PS_W)) u_smp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .stb_i  (sample_stb_o),
    .tick_i (bit_tick_o),
    .ps_i   (ps),
    .mid_i  (mid),
    .vote_i (vote),
    .rx_i   (rx_i),
    .bit_o  (rx_bit_o),
    .vld_o  (rx_bit_vld_o)
  );

  AST_ZERO_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_cfg_o |-> !sample_stb_o && !bit_tick_o); // R8

  AST_STB_NOT_BACK_TO_BACK_WIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_stb_o && reload > 1 && !restart) |=> !sample_stb_o); // R4

endmodule

// File: tb/ser_rate_gen_tb.sv
`timescale 1ns/1ps
module ser_rate_gen_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_lo = 1'b0, wr_hi = 1'b0, wr_mode = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rx = 1'b0;
  logic       stb, tick, bad, rbit, rvld;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ser_rate_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_lo_i(wr_lo), .wr_hi_i(wr_hi),
    .wr_mode_i(wr_mode), .wr_data_i(wr_data), .rx_i(rx),
    .sample_stb_o(stb), .bit_tick_o(tick), .bad_cfg_o(bad),
    .rx_bit_o(rbit), .rx_bit_vld_o(rvld)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int presc(input bit s, input bit w, input bit f);
    if (s || (w && f)) return 4;
    if (w || f) return 16;
    return 64;
  endfunction

  task automatic wr(input bit l, input bit h, input bit m, input logic [7:0] d);
    @(negedge clk);
    wr_lo = l; wr_hi = h; wr_mode = m; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_lo = 0; wr_hi = 0; wr_mode = 0;
  endtask

  // mode write, high byte, then low byte last; latency counts from the last write
  task automatic cfg(input bit s, input bit w, input bit f, input logic [7:0] h, input logic [7:0] l);
    wr(0, 0, 1, {5'd0, s, w, f});
    wr(0, 1, 0, h);
    wr(1, 0, 0, l);
  endtask

  task automatic measure(input int per, input int p, input string req);
    int lat = 1;
    int cyc = 0;
    int nst = 0;
    while (!tick && lat < 40000) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == per, {req, " first tick after write"}, lat, per);
    do begin
      @(negedge clk);
      cyc++;
      if (stb) nst++;
    end while (!tick && cyc < 40000);
    chk(cyc == per, {req, " bit period"}, cyc, per);
    chk(nst == p, {req, " strobes per bit"}, nst, p);
  endtask

  task automatic vote_run(input bit s, input bit w, input bit f, input int nbits, input string req);
    int p = presc(s, w, f);
    int mid = p / 2;
    bit vt = (p != 4);
    bit pat [64];
    int k = 0;
    int got = 0;
    bit pend = 0;
    bit exp_b = 0;
    int guard = 0;
    foreach (pat[i]) pat[i] = $urandom_range(0, 1);
    cfg(s, w, f, 8'd0, 8'd1);
    while (got < nbits && guard < 20000) begin
      guard++;
      if (pend) begin
        chk(rvld == 1'b1, {req, " valid after tick"}, rvld, 1);
        chk(rbit == exp_b, {req, " resolved bit"}, rbit, exp_b);
        pend = 0;
        got++;
      end
      rx = pat[k];
      if (tick) begin
        exp_b = vt ? ((pat[mid-1] & pat[mid]) | (pat[mid-1] & pat[mid+1]) | (pat[mid] & pat[mid+1]))
                   : pat[mid];
        pend = 1;
        k = 0;
        foreach (pat[i]) pat[i] = $urandom_range(0, 1);
      end else if (stb) begin
        k++;
      end
      @(negedge clk);
    end
    chk(got == nbits, {req, " bits resolved"}, got, nbits);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(bad == 1'b1, "R1 bad_cfg after reset", bad, 1);
    chk(stb == 1'b0 && tick == 1'b0, "R1 strobes quiet after reset", stb | tick, 0);
    chk(rvld == 1'b0 && rbit == 1'b0, "R1 sampler outputs after reset", rvld | rbit, 0);

    // R11 reference: 16 MHz / 1664 = 9615 baud
    cfg(0, 0, 0, 8'd0, 8'd25);
    measure(1664, 64, "R11");

    // R2 high byte ignored in 8-bit mode
    cfg(0, 0, 0, 8'd5, 8'd3);
    measure(64 * 4, 64, "R2");

    // R3 wide reload {hi,lo}
    cfg(0, 1, 0, 8'd1, 8'd2);
    measure(16 * 259, 16, "R3");

    // R4 / R5 / R6 per mode
    cfg(0, 0, 0, 8'd0, 8'd2);
    measure(64 * 3, 64, "R4");
    cfg(0, 0, 1, 8'd0, 8'd4);
    measure(16 * 5, 16, "R5");
    cfg(0, 1, 1, 8'd0, 8'd6);
    measure(4 * 7, 4, "R6 async both");
    cfg(1, 0, 0, 8'd0, 8'd5);
    measure(4 * 6, 4, "R6 sync fast=0");
    cfg(1, 0, 1, 8'd0, 8'd5);
    measure(4 * 6, 4, "R6 sync fast=1");
    cfg(1, 1, 0, 8'd0, 8'd5);
    measure(4 * 6, 4, "R6 sync wide");

    // R7 restart mid-period: rewrite low byte while running
    cfg(0, 0, 0, 8'd0, 8'd7);
    repeat (100) @(negedge clk);
    wr(1, 0, 0, 8'd1);
    measure(64 * 2, 64, "R7 rewrite mid-period");

    // R8 zero reload
    cfg(0, 0, 0, 8'd9, 8'd0);
    begin
      int seen = 0;
      int badlow = 0;
      repeat (400) begin
        @(negedge clk);
        if (stb || tick) seen++;
        if (!bad) badlow++;
      end
      chk(seen == 0, "R8 no strobes at zero reload", seen, 0);
      chk(badlow == 0, "R8 bad_cfg held", badlow, 0);
    end
    cfg(0, 1, 0, 8'd1, 8'd0);
    chk(bad == 1'b0, "R8 wide reload 256 is valid", bad, 0);

    // R7 random modes and divisors, latency and period
    for (int it = 0; it < 10; it++) begin
      bit s = $urandom_range(0, 1);
      bit w = $urandom_range(0, 1);
      bit f = $urandom_range(0, 1);
      int l = $urandom_range(1, 7);
      int h = w ? 0 : $urandom_range(0, 255);
      cfg(s, w, f, 8'(h), 8'(l));
      measure(presc(s, w, f) * (l + 1), presc(s, w, f), "R7 random");
    end

    // R9 sampler, R10 tick within strobe
    vote_run(0, 0, 0, 6, "R9 vote P64");
    vote_run(0, 0, 1, 6, "R9 vote P16");
    vote_run(0, 1, 1, 8, "R9 single P4");
    vote_run(1, 0, 1, 8, "R9 single sync");
    begin
      int bad_tick = 0;
      cfg(0, 0, 1, 8'd0, 8'd1);
      repeat (300) begin
        @(negedge clk);
        if (tick && !stb) bad_tick++;
      end
      chk(bad_tick == 0, "R10 tick only with strobe", bad_tick, 0);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule